// File: doc/BRIEF.md
# Power Management Event Controller

This block holds the fixed power-management event state of a platform: a status register, a matching enable register, a control register carrying the SCI enable and the sleep request field, a free-running power-management timer, and a pair of byte-wide command and status ports that firmware uses as its mailbox. Software reaches all of it through a small dword register bus with per-byte lane enables. The block drives a level interrupt toward the operating system and single-cycle request pulses toward the firmware trap logic and the platform power sequencer.

Status bits are raised by hardware events and cleared by software writing ones. These events are a timer overflow, a power-button press and a resume after a fake sleep. The interrupt line is high whenever an event that has an interrupt source is both pending and enabled. A control write with the sleep-enable bit set either asks the platform to power off or simulates a suspend-and-resume by marking resume and power-button status before asking for a reset. Writing the two reserved command values switches the SCI enable bit on or off, and any command write can trap to firmware when the platform allows it.

Top module: `pm_evt_ctrl`

## Requirements
- R1: After reset every register reads zero and sci_o, smi_o, shutdown_o and reset_o are low.
- R2: The bus decodes dword words by addr_i[3:2]: word 0 holds status in bits 15:0 and enable in bits 31:16, word 1 holds control in bits 15:0, word 2 holds the timer, word 3 holds the command byte in bits 7:0 and the mailbox status byte in bits 15:8. Only lanes with be_i set are written. Addresses with nonzero bits 1:0 or above bit 3 are ignored.
- R3: Status bits are write-one-to-clear. Only bits 15 (resume), 8 (power button) and 0 (timer overflow) are implemented. A write takes effect at the clock edge that samples it.
- R4: sci_o is high exactly when status AND enable is nonzero over bits 10, 8, 5 and 0. It follows the registers without extra delay.
- R5: The timer advances by one on each clock with tick_i high. Writes to word 2 have no effect.
- R6: The timer overflow status bit (bit 0) is set when the timer's most significant bit changes value.
- R7: A control write stores every written bit except bit 13 (sleep enable), which always reads zero. Bit 0 is the SCI enable.
- R8: A control write with bit 13 set and sleep type (bits 12:10) equal to 0 pulses shutdown_o for one cycle.
- R9: With bit 13 set and sleep type 1, status bits 15 and 8 are set and reset_o pulses for one cycle.
- R10: With bit 13 set and any other sleep type, neither request pulses and status is unchanged.
- R11: The command byte and the mailbox status byte each read back their last written value.
- R12: Writing 0xF1 to the command byte sets control bit 0. Writing 0xF0 clears it. Other values leave it unchanged.
- R13: Every command-byte write pulses smi_o for one cycle if smi_en_i is high, and never otherwise.
- R14: A pwrbtn_i pulse sets status bit 8 only while enable bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the dword access |
| wr_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tick_i | input | 1 | Timer advance enable (3.579545 MHz rate) |
| pwrbtn_i | input | 1 | Power-button event pulse |
| smi_en_i | input | 1 | Platform permission to trap on command writes |
| sci_o | output | 1 | Level system control interrupt |
| smi_o | output | 1 | One-cycle firmware trap request |
| shutdown_o | output | 1 | One-cycle soft power-off request |
| reset_o | output | 1 | One-cycle system reset request |

## Verification
Every register effect, the request pulses and smi_o become visible one clock edge after the edge that samples the write or event. sci_o and rdata_o are combinational from those registers and so change in that same cycle. The bench drives inputs on the falling edge and checks on the following falling edge, after exactly one rising edge has passed. The timer is run with a narrow width so that the edge where its top bit flips can be reached. The value one tick before the flip and the value at the flip are both checked.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  typedef enum logic [1:0] {
    W_EVT = 2'd0,
    W_CTL = 2'd1,
    W_TMR = 2'd2,
    W_APM = 2'd3
  } reg_word_e;

  localparam int unsigned B_TMROF  = 0;
  localparam int unsigned B_PWRBTN = 8;
  localparam int unsigned B_RSM    = 15;
  localparam int unsigned B_SCIEN  = 0;
  localparam int unsigned B_SUSEN  = 13;
  localparam int unsigned SLP_LSB  = 10;

  localparam logic [15:0] SCI_MASK = 16'h0521;  // rtc, pwrbtn, global, tmrof
  localparam logic [15:0] STS_IMPL = 16'h8101;
  localparam logic [7:0]  CMD_ON   = 8'hF1;
  localparam logic [7:0]  CMD_OFF  = 8'hF0;

  function automatic logic [15:0] lane_merge(logic [15:0] old_v, logic [15:0] new_v,
                                             logic [1:0] be);
    return {be[1] ? new_v[15:8] : old_v[15:8], be[0] ? new_v[7:0] : old_v[7:0]};
  endfunction
endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + TMR_W'(1);
  assign ovf_o   = tick_i & (cnt_q[TMR_W-1] ^ cnt_nxt[TMR_W-1]);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  // R5
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == $past(cnt_o) + TMR_W'(1));
  // R5
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pm_apm.sv
module pm_apm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic       sts_we_i,
  input  logic [7:0] cmd_wdata_i,
  input  logic [7:0] sts_wdata_i,
  input  logic       smi_en_i,
  output logic [7:0] cmd_o,
  output logic [7:0] sts_o,
  output logic       acpi_on_o,
  output logic       acpi_off_o,
  output logic       smi_o
);
  import pm_evt_pkg::*;

  logic [7:0] cmd_q, sts_q;
  logic       smi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= '0;
      smi_q <= 1'b0;
    end else begin
      if (cmd_we_i) cmd_q <= cmd_wdata_i;
      if (sts_we_i) sts_q <= sts_wdata_i;
      smi_q <= cmd_we_i & smi_en_i;
    end
  end

  assign acpi_on_o  = cmd_we_i & (cmd_wdata_i == CMD_ON);
  assign acpi_off_o = cmd_we_i & (cmd_wdata_i == CMD_OFF);
  assign cmd_o      = cmd_q;
  assign sts_o      = sts_q;
  assign smi_o      = smi_q;

  // R13
  smi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(smi_en_i) && $past(cmd_we_i));
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TMR_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  input  logic              pwrbtn_i,
  input  logic              smi_en_i,
  output logic              sci_o,
  output logic              smi_o,
  output logic              shutdown_o,
  output logic              reset_o
);
  import pm_evt_pkg::*;

  logic [15:0] sts_q, en_q, ctl_q;
  logic [15:0] sts_set, sts_clr, ctl_d;
  logic        shut_q, rst_q;
  logic        hit, wr_evt, wr_ctl, wr_apm, sus_wr, resume;
  logic [2:0]  slp_typ;
  reg_word_e   word;
  logic [TMR_W-1:0] tmr_cnt;
  logic        tmr_ovf, acpi_on, acpi_off;
  logic [7:0]  apm_cmd, apm_sts;

  assign hit    = ((addr_i >> 4) == '0) && (addr_i[1:0] == 2'b00);
  assign word   = reg_word_e'(addr_i[3:2]);
  assign wr_evt = wr_i & hit & (word == W_EVT);
  assign wr_ctl = wr_i & hit & (word == W_CTL);
  assign wr_apm = wr_i & hit & (word == W_APM);

  pm_tmr #(.TMR_W(TMR_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (tmr_cnt),
    .ovf_o  (tmr_ovf)
  );

  pm_apm i_apm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (wr_apm & be_i[0]),
    .sts_we_i    (wr_apm & be_i[1]),
    .cmd_wdata_i (wdata_i[7:0]),
    .sts_wdata_i (wdata_i[15:8]),
    .smi_en_i    (smi_en_i),
    .cmd_o       (apm_cmd),
    .sts_o       (apm_sts),
    .acpi_on_o   (acpi_on),
    .acpi_off_o  (acpi_off),
    .smi_o       (smi_o)
  );

  // sleep request decode
  assign sus_wr  = wr_ctl & be_i[1] & wdata_i[B_SUSEN];
  assign slp_typ = wdata_i[SLP_LSB +: 3];
  assign resume  = sus_wr & (slp_typ == 3'd1);

  assign sts_clr = wr_evt ? lane_merge(16'h0, wdata_i[15:0], be_i[1:0]) : 16'h0;

  always_comb begin
    sts_set           = '0;
    sts_set[B_TMROF]  = tmr_ovf;
    sts_set[B_PWRBTN] = (pwrbtn_i & en_q[B_PWRBTN]) | resume;
    sts_set[B_RSM]    = resume;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d          = lane_merge(ctl_q, wdata_i[15:0], be_i[1:0]);
      ctl_d[B_SUSEN] = 1'b0;
    end
    if (acpi_on)  ctl_d[B_SCIEN] = 1'b1;
    if (acpi_off) ctl_d[B_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      shut_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      sts_q  <= ((sts_q & ~sts_clr) | sts_set) & STS_IMPL;  // event wins over clear
      if (wr_evt) en_q <= lane_merge(en_q, wdata_i[31:16], be_i[3:2]);
      ctl_q  <= ctl_d;
      shut_q <= sus_wr & (slp_typ == 3'd0);
      rst_q  <= resume;
    end
  end

  assign sci_o      = |(sts_q & en_q & SCI_MASK);
  assign shutdown_o = shut_q;
  assign reset_o    = rst_q;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (word)
        W_EVT: rdata_o = {en_q, sts_q};
        W_CTL: rdata_o = {16'h0, ctl_q};
        W_TMR: rdata_o = 32'(tmr_cnt);
        W_APM: rdata_o = {16'h0, apm_sts, apm_cmd};
        default: rdata_o = '0;
      endcase
    end
  end

  // R14
  pwrbtn_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[B_PWRBTN]) |-> $past(en_q[B_PWRBTN]) || reset_o);
  // R9
  resume_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> sts_q[B_RSM] && sts_q[B_PWRBTN]);
  // R12
  acpi_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acpi_on |=> ctl_q[B_SCIEN]);
  // R12
  acpi_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acpi_off |=> !ctl_q[B_SCIEN]);
  // R8
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_o && reset_o));
  // R4
  sci_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> (en_q & SCI_MASK) != '0);
endmodule

// File: tb/test_pm_evt_ctrl.sv
module test_pm_evt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0, pwrbtn = 1'b0, smi_en = 1'b0;
  logic        sci, smi, shutdown, rst_req;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_evt_ctrl #(.ADDR_W(4), .TMR_W(TW)) i_pm_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .pwrbtn_i(pwrbtn),
    .smi_en_i(smi_en), .sci_o(sci), .smi_o(smi), .shutdown_o(shutdown),
    .reset_o(rst_req)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [3:0]  wbe;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp;
    logic        sci;
    logic [31:0] tag;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'h0, 4'b1100, 32'h0100_0000, 4'h0, 32'h0100_0000, 1'b0, "R2  "},
    '{4'h4, 4'b0011, 32'h0000_0401, 4'h4, 32'h0000_0401, 1'b0, "R7  "},
    '{4'h4, 4'b0001, 32'h0000_FF00, 4'h4, 32'h0000_0400, 1'b0, "R2  "},
    '{4'hC, 4'b0011, 32'h0000_5AC3, 4'hC, 32'h0000_5AC3, 1'b0, "R11 "},
    '{4'h8, 4'b1111, 32'hFFFF_FFFF, 4'h8, 32'h0000_0000, 1'b0, "R5  "},
    '{4'hC, 4'b0001, 32'h0000_00F1, 4'h4, 32'h0000_0401, 1'b0, "R12 "},
    '{4'hC, 4'b0001, 32'h0000_0000, 4'h4, 32'h0000_0401, 1'b0, "R12 "},
    '{4'hC, 4'b0001, 32'h0000_00F0, 4'h4, 32'h0000_0400, 1'b0, "R12 "},
    '{4'h4, 4'b0011, 32'h0000_3C00, 4'h4, 32'h0000_1C00, 1'b0, "R7  "}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      rd_reg(4'(w*4), v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {28'h0, sci, smi, shutdown, rst_req}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      wr_reg(VECS[i].wa, VECS[i].wbe, VECS[i].wd);
      rd_reg(VECS[i].ra, v);
      chk($sformatf("%s row %0d", VECS[i].tag, i), v, VECS[i].exp);
      chk($sformatf("%s sci row %0d", VECS[i].tag, i), {31'h0, sci}, {31'h0, VECS[i].sci});
    end

    // R2 misaligned address ignored
    wr_reg(4'h5, 4'b1111, 32'hFFFF_FFFF);
    rd_reg(4'h4, v);
    chk("R2 misaligned", v, 32'h0000_1C00);

    // R14 power button with enable clear
    wr_reg(4'h0, 4'b1100, 32'h0);
    @(negedge clk); pwrbtn = 1'b1;
    @(negedge clk); pwrbtn = 1'b0;
    rd_reg(4'h0, v);
    chk("R14 gated", v, 32'h0);
    // R14 / R4 with enable set
    wr_reg(4'h0, 4'b1100, 32'h0100_0000);
    @(negedge clk); pwrbtn = 1'b1;
    @(negedge clk); pwrbtn = 1'b0;
    rd_reg(4'h0, v);
    chk("R14 set", v, 32'h0100_0100);
    chk("R4 sci on", {31'h0, sci}, 32'h1);
    // R3 write-one-to-clear, sci drops at once
    wr_reg(4'h0, 4'b0010, 32'h0000_0100);
    rd_reg(4'h0, v);
    chk("R3 clear", v, 32'h0100_0000);
    chk("R4 sci off", {31'h0, sci}, 32'h0);

    // R8 soft off
    wr_reg(4'h4, 4'b0011, 32'h0000_2000);
    chk("R8 pulse", {30'h0, shutdown, rst_req}, 32'h2);
    @(negedge clk);
    chk("R8 one cycle", {31'h0, shutdown}, 32'h0);

    // R9 fake resume
    wr_reg(4'h4, 4'b0011, 32'h0000_2400);
    chk("R9 pulse", {30'h0, shutdown, rst_req}, 32'h1);
    rd_reg(4'h0, v);
    chk("R9 status", v, 32'h0100_8100);
    chk("R9 sci", {31'h0, sci}, 32'h1);
    @(negedge clk);
    chk("R9 one cycle", {31'h0, rst_req}, 32'h0);
    wr_reg(4'h0, 4'b0011, 32'h0000_FFFF);

    // R10 other sleep type
    wr_reg(4'h4, 4'b0011, 32'h0000_2C00);
    chk("R10 no pulse", {30'h0, shutdown, rst_req}, 32'h0);
    rd_reg(4'h0, v);
    chk("R10 status", v, 32'h0100_0000);

    // R13 trap gating
    smi_en = 1'b0;
    wr_reg(4'hC, 4'b0001, 32'h0000_0012);
    chk("R13 no smi", {31'h0, smi}, 32'h0);
    smi_en = 1'b1;
    wr_reg(4'hC, 4'b0001, 32'h0000_0034);
    chk("R13 smi", {31'h0, smi}, 32'h1);
    @(negedge clk);
    chk("R13 one cycle", {31'h0, smi}, 32'h0);
    smi_en = 1'b0;

    // R5 / R6 timer and overflow
    wr_reg(4'h0, 4'b0100, 32'h0001_0000);
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 127; k++) @(negedge clk);
    tick = 1'b0;
    rd_reg(4'h8, v);
    chk("R5 count", v, 32'd127);
    rd_reg(4'h0, v);
    chk("R6 before flip", v, 32'h0101_0000);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd_reg(4'h8, v);
    chk("R5 count msb", v, 32'd128);
    rd_reg(4'h0, v);
    chk("R6 at flip", v, 32'h0101_0001);
    chk("R4 sci tmr", {31'h0, sci}, 32'h1);

    done = 1'b1;
    summary();
  end
endmodule